// File: doc/BRIEF.md
# Pulse-Qualified Set/Reset Trigger Model

This block reproduces, on a fast synchronous clock, the behaviour of an old discrete set/reset trigger whose set and reset inputs were capacitively coupled. It stores a single state bit and presents it as a pair of complementary outputs. Two set inputs and two clear inputs each have an enabling gate level. Each of these inputs acts only on a positive-going pulse. A positive-going pulse means the input was sampled low and then high on the following `HIST_LEN-1` edges. A level that stays high never acts twice.

Two override inputs model a wired gate tied onto the outputs. They drive the trigger on or off directly, and they also wipe every input's pulse history so that nothing half-seen survives the override. A gate whose pin was grounded in the old circuit counts as permanently enabled. It is selected per input by a parameter. Several instances can be cascaded: one stage's output gates the next stage's set input, while a shared pulse clears the first stage. The hand-off works because the state only moves at the clock edge.

Top module: `ac_trigger`

## Requirements
- R1: Each pulse input keeps its own history of its last `HIST_LEN` (default 3) clock samples. It produces an event only when the oldest sample is 0 and every newer sample is 1. The trigger output changes on the edge after the cycle in which the event is present, so with the defaults `q_on` changes at the third edge after the first high sample. A high level seen on fewer than `HIST_LEN-1` consecutive samples produces no event.
- R2: An input that stays high produces exactly one event. It cannot produce another until it has been sampled low again.
- R3: A set event drives the state to 1 and a clear event drives it to 0. Each takes effect only if its own gate input is 1 in the cycle the event is present. With the gate at 0, the event has no effect.
- R4: A gate whose bit is set in `SET_TIED` or `CLR_TIED` is treated as always 1, whatever its gate pin does. The defaults are `SET_TIED = 2'b10` (set input 1 tied) and `CLR_TIED = 2'b00`.
- R5: `force_on` drives the state to 1 at the next edge, and `force_off` drives it to 0. When both are high, `force_off` wins.
- R6: On any edge where a force input is high, all four pulse histories are cleared to 0. An input still held high afterwards is therefore seen as a fresh pulse.
- R7: If a gated set event and a gated clear event are present in the same cycle and no force is active, the state keeps its value.
- R8: A force input overrides any set or clear event present in the same cycle.
- R9: `q_on` equals the registered state and `q_off` is always its complement.
- R10: A synchronous active-high `rst` clears the state (`q_on`=0, `q_off`=1) and every pulse history.
- R11: The state changes only at a clock edge. When a pulse clears this stage and, through a gate tied to `q_on`, sets a following stage, the following stage sees the state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse | input | N_SET | Pulse-coupled set inputs |
| set_gate | input | N_SET | Gate level for each set input |
| clr_pulse | input | N_CLR | Pulse-coupled clear inputs |
| clr_gate | input | N_CLR | Gate level for each clear input |
| force_on | input | 1 | Override that drives the trigger on |
| force_off | input | 1 | Override that drives the trigger off (dominant) |
| q_on | output | 1 | Registered state |
| q_off | output | 1 | Complement of the state |

## Verification
The assertions check the following on every cycle:
- an event never appears on two consecutive cycles;
- an event never follows a force edge directly;
- the force inputs always land on the state at the next edge;
- a solitary gated event moves the state;
- simultaneous events leave the state unchanged.

Some behaviours only the bench's scenarios can show:
- a one-cycle glitch is ignored;
- a held level re-arms only after a low;
- a tied gate ignores its pin;
- a held input fires again after a force has wiped its history;
- a cascaded second stage picks up the first stage's pre-edge state.

A cycle-level reference model runs alongside the design and is compared with its outputs throughout.

// File: rtl/ac_trigger_pkg.sv
package ac_trigger_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } trig_act_t;

  function automatic trig_act_t decide(input logic f_on, input logic f_off,
                                       input logic s_ev, input logic c_ev);
    if (f_off)             return ACT_CLR;
    else if (f_on)         return ACT_SET;
    else if (s_ev && !c_ev) return ACT_SET;
    else if (c_ev && !s_ev) return ACT_CLR;
    else                   return ACT_HOLD;
  endfunction
endpackage

// File: rtl/pulse_history.sv
module pulse_history #(
  parameter int HIST_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic din,
  output logic fire
);
  logic [HIST_LEN-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst || clear) hist <= '0;
    else              hist <= {hist[HIST_LEN-2:0], din};
  end

  assign fire = !hist[HIST_LEN-1] && (&hist[HIST_LEN-2:0]);

  // R2: a fired history is shifted so the oldest sample becomes 1
  a_r2_no_refire: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
  // R6: a forced clear wipes any pending pulse
  a_r6_clear_wipes: assert property (@(posedge clk) disable iff (rst)
    clear |=> !fire);
  // R1: an event needs the input high at the previous sample
  a_r1_high_sample: assert property (@(posedge clk) disable iff (rst)
    fire |-> ($past(din) && !$past(clear)));
endmodule

// File: rtl/gate_combine.sv
module gate_combine #(
  parameter int             N    = 2,
  parameter logic [N-1:0]   TIED = '0
) (
  input  logic [N-1:0] fire,
  input  logic [N-1:0] gate,
  output logic         any_event
);
  logic [N-1:0] qual;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (TIED[i]) begin : g_tied
      assign qual[i] = fire[i] | (gate[i] & 1'b0);
    end else begin : g_pin
      assign qual[i] = fire[i] & gate[i];
    end
  end

  assign any_event = |qual;
endmodule

// File: rtl/trigger_state.sv
module trigger_state
  import ac_trigger_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic force_on,
  input  logic force_off,
  input  logic set_evt,
  input  logic clr_evt,
  output logic state
);
  trig_act_t act;

  assign act = decide(force_on, force_off, set_evt, clr_evt);

  always_ff @(posedge clk) begin
    if (rst) state <= 1'b0;
    else begin
      unique case (act)
        ACT_SET: state <= 1'b1;
        ACT_CLR: state <= 1'b0;
        default: state <= state;
      endcase
    end
  end

  // R5: force_off dominates
  a_r5_force_off: assert property (@(posedge clk) disable iff (rst)
    force_off |=> !state);
  // R5: force_on alone
  a_r5_force_on: assert property (@(posedge clk) disable iff (rst)
    (force_on && !force_off) |=> state);
  // R7: conflicting events hold the state
  a_r7_conflict_hold: assert property (@(posedge clk) disable iff (rst)
    (!force_on && !force_off && set_evt && clr_evt) |=> $stable(state));
  // R3: a lone set event sets
  a_r3_lone_set: assert property (@(posedge clk) disable iff (rst)
    (!force_on && !force_off && set_evt && !clr_evt) |=> state);
  // R3: a lone clear event clears
  a_r3_lone_clr: assert property (@(posedge clk) disable iff (rst)
    (!force_on && !force_off && clr_evt && !set_evt) |=> !state);
endmodule

// File: rtl/ac_trigger.sv
module ac_trigger #(
  parameter int               HIST_LEN = 3,
  parameter int               N_SET    = 2,
  parameter int               N_CLR    = 2,
  parameter logic [N_SET-1:0] SET_TIED = 2'b10,
  parameter logic [N_CLR-1:0] CLR_TIED = 2'b00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SET-1:0] set_pulse,
  input  logic [N_SET-1:0] set_gate,
  input  logic [N_CLR-1:0] clr_pulse,
  input  logic [N_CLR-1:0] clr_gate,
  input  logic             force_on,
  input  logic             force_off,
  output logic             q_on,
  output logic             q_off
);
  logic             wipe;
  logic [N_SET-1:0] set_fire;
  logic [N_CLR-1:0] clr_fire;
  logic             set_evt, clr_evt;
  logic             state;

  assign wipe = force_on | force_off;

  for (genvar i = 0; i < N_SET; i++) begin : g_set
    pulse_history #(.HIST_LEN(HIST_LEN)) u_hist (
      .clk(clk), .rst(rst), .clear(wipe), .din(set_pulse[i]), .fire(set_fire[i]));
  end

  for (genvar j = 0; j < N_CLR; j++) begin : g_clr
    pulse_history #(.HIST_LEN(HIST_LEN)) u_hist (
      .clk(clk), .rst(rst), .clear(wipe), .din(clr_pulse[j]), .fire(clr_fire[j]));
  end

  gate_combine #(.N(N_SET), .TIED(SET_TIED)) u_set_gate (
    .fire(set_fire), .gate(set_gate), .any_event(set_evt));

  gate_combine #(.N(N_CLR), .TIED(CLR_TIED)) u_clr_gate (
    .fire(clr_fire), .gate(clr_gate), .any_event(clr_evt));

  trigger_state u_state (
    .clk(clk), .rst(rst), .force_on(force_on), .force_off(force_off),
    .set_evt(set_evt), .clr_evt(clr_evt), .state(state));

  assign q_on  = state;
  assign q_off = ~state;

  // R10: reset leaves the trigger off
  a_r10_reset_off: assert property (@(posedge clk)
    rst |=> (!q_on && q_off));
  // R8: force beats any event in the same cycle
  a_r8_force_beats_event: assert property (@(posedge clk) disable iff (rst)
    (force_off && set_evt) |=> !q_on);
endmodule

// File: tb/ac_trigger_test.sv
`timescale 1ns/1ps
module ac_trigger_test;
  localparam logic [1:0] SET_TIED = 2'b10;
  localparam logic [1:0] CLR_TIED = 2'b00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] sp = '0, sg = '0, rp = '0, rg = '0;
  logic fon = 1'b0, foff = 1'b0;
  logic q_on, q_off, n_on, n_off;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ac_trigger #(.SET_TIED(SET_TIED), .CLR_TIED(CLR_TIED)) uut (
    .clk(clk), .rst(rst), .set_pulse(sp), .set_gate(sg),
    .clr_pulse(rp), .clr_gate(rg), .force_on(fon), .force_off(foff),
    .q_on(q_on), .q_off(q_off));

  // R11: second stage of a chain, set by the pulse that clears uut
  ac_trigger #(.SET_TIED(SET_TIED), .CLR_TIED(CLR_TIED)) uut_next (
    .clk(clk), .rst(rst), .set_pulse({1'b0, rp[1]}), .set_gate({1'b0, q_on}),
    .clr_pulse(2'b00), .clr_gate(2'b00), .force_on(1'b0), .force_off(1'b0),
    .q_on(n_on), .q_off(n_off));

  // behavioural reference: per-input sample queue, newest at front
  bit mh[4][$];
  bit mstate = 0;

  always @(posedge clk) begin
    bit din[4];
    bit gt[4];
    bit ev[4];
    bit s_ev, c_ev;
    din = '{sp[0], sp[1], rp[0], rp[1]};
    gt  = '{sg[0] | SET_TIED[0], sg[1] | SET_TIED[1], rg[0] | CLR_TIED[0], rg[1] | CLR_TIED[1]};
    for (int i = 0; i < 4; i++) begin
      while (mh[i].size() < 3) mh[i].push_back(1'b0);
      ev[i] = (mh[i][2] == 1'b0) && mh[i][1] && mh[i][0] && gt[i];
    end
    s_ev = ev[0] || ev[1];
    c_ev = ev[2] || ev[3];
    if (rst) mstate = 0;
    else if (foff) mstate = 0;
    else if (fon) mstate = 1;
    else if (s_ev && !c_ev) mstate = 1;
    else if (c_ev && !s_ev) mstate = 0;
    for (int i = 0; i < 4; i++) begin
      if (rst || fon || foff) begin
        mh[i].delete();
        repeat (3) mh[i].push_back(1'b0);
      end else begin
        mh[i].push_front(din[i]);
        void'(mh[i].pop_back());
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (q_on !== mstate || q_off !== !mstate) begin
        errors++;
        $display("FAIL R1 R3 R9 model compare t=%0t: q_on=%b q_off=%b expected %b/%b",
                 $time, q_on, q_off, mstate, !mstate);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rg[1] = 1'b1;
    step(3);
    rst = 1'b0;
    check("R10 q_on after reset", q_on, 1'b0);
    check("R10 q_off after reset", q_off, 1'b1);
    check("R10 chained stage after reset", n_on, 1'b0);

    sg[0] = 1; sp[0] = 1; step(2);
    check("R1 no change before third edge", q_on, 1'b0);
    step(1);
    check("R1 set on third edge", q_on, 1'b1);
    check("R9 complement", q_off, 1'b0);

    rg[0] = 1; rp[0] = 1; step(3); rp[0] = 0;
    check("R3 gated clear", q_on, 1'b0);
    step(5);
    check("R2 held set input no retrigger", q_on, 1'b0);
    sp[0] = 0; step(1); sp[0] = 1; step(3);
    check("R2 re-armed after low", q_on, 1'b1);

    rp[0] = 1; step(3); rp[0] = 0;
    sp[0] = 0; step(2);
    sp[0] = 1; step(1); sp[0] = 0; step(4);
    check("R1 single-sample glitch ignored", q_on, 1'b0);

    sg[0] = 0; sp[0] = 1; step(4); sp[0] = 0; step(1);
    check("R3 set with gate low ignored", q_on, 1'b0);

    sg[1] = 0; sp[1] = 1; step(3); sp[1] = 0;
    check("R4 tied gate sets", q_on, 1'b1);

    rg[0] = 0; rp[0] = 1; step(4); rp[0] = 0; step(1);
    check("R3 clear with gate low ignored", q_on, 1'b1);

    sg[0] = 1; rg[0] = 1; sp[0] = 1; rp[0] = 1; step(4);
    sp[0] = 0; rp[0] = 0;
    check("R7 simultaneous set and clear hold 1", q_on, 1'b1);
    step(1);

    foff = 1; step(1); foff = 0;
    check("R5 force_off", q_on, 1'b0);
    check("R9 complement after force", q_off, 1'b1);
    fon = 1; step(1); fon = 0;
    check("R5 force_on", q_on, 1'b1);
    fon = 1; foff = 1; step(1); fon = 0; foff = 0;
    check("R5 both forces give off", q_on, 1'b0);

    sp[0] = 1; step(2); foff = 1; step(1); foff = 0;
    check("R8 force_off beats set event", q_on, 1'b0);
    step(2);
    check("R6 no set before refill", q_on, 1'b0);
    step(1);
    check("R6 held input refires after wipe", q_on, 1'b1);
    sp[0] = 0; step(2);

    check("R11 chain stage idle before pulse", n_on, 1'b0);
    rp[1] = 1; step(3);
    check("R11 first stage cleared by shared pulse", q_on, 1'b0);
    check("R11 next stage took pre-edge state", n_on, 1'b1);
    check("R9 chained complement", n_off, 1'b0);
    rp[1] = 0; step(1); rp[1] = 1; step(3); rp[1] = 0; step(1);
    check("R11 first stage stays off", q_on, 1'b0);
    check("R11 next stage keeps its state", n_on, 1'b1);

    finish_run();
  end
endmodule